// File: doc/BRIEF.md
# Dual-Compare 8-bit PWM Timer

An 8-bit timer/counter advances on strobes from an external prescaler. Two compare channels, A and B, watch the count and drive one waveform pin each. A mode field selects one of four behaviours: free counting, clear on compare A, single-slope PWM and dual-slope PWM. Software programs the block through a small write port. That port loads the counter, the two compare values and a control byte. The control byte holds a run bit, the mode and one output action per channel.

The block reports three events through sticky flags: counter overflow, compare A match and compare B match. Each flag is cleared by its own acknowledge input. In the two PWM modes the compare values are double-buffered, and a new value takes effect only at a fixed point in the count cycle, so a pulse is never cut short. A write to the counter masks compare matches for the following tick. A force strobe applies a channel's output action at once, without setting its flag or touching the count.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0x00, both waveform pins are low and all three flags are clear.
- R2: Select 0 writes the count and select 3 writes the control byte (bits [1:0] mode, [3:2] channel A action, [5:4] channel B action, bit 6 run). The count changes only on a tick while run is 1. In mode 00 it increments and wraps from 0xFF to 0x00, and that wrap sets the overflow flag.
- R3: In mode 01 the counter counts up to compare A. On the next tick it returns to 0x00, and that tick sets the compare A flag.
- R4: After a count write, the next tick produces no compare match on either channel. In mode 01 it also does not clear the counter.
- R5: Select 1 writes compare A and select 2 writes compare B. In modes 00 and 01 a written value applies at once, and on a match the channel action is applied: 01 toggles the pin, 10 drives it low and 11 drives it high. Action 00 holds the pin low and keeps the pin's internal state.
- R6: In modes 00 and 01, a force strobe applies the channel action in the same cycle. It leaves the flags and the count unchanged.
- R7: In mode 10 the count runs from 0x00 to 0xFF and wraps, which sets the overflow flag. With action 10 the pin is high while count <= compare, and action 11 gives the complement. A compare value of 0xFF therefore gives a constant level.
- R8: In modes 10 and 11 a compare write goes to a buffer. The buffer moves to the active compare on the tick that leaves count 0xFF.
- R9: In mode 11 the count goes up from 0x00 to 0xFF and then back down to 0x00. The tick that reaches 0x00 sets the overflow flag. With action 10 the pin is high while count < compare.
- R10: An acknowledge clears its flag. If a new event for the same flag occurs in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 compare A, 2 compare B, 3 control |
| wr_data | input | 8 | Write data |
| force_a | input | 1 | Force compare strobe, channel A |
| force_b | input | 1 | Force compare strobe, channel B |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_a | input | 1 | Clears the compare A flag |
| ack_b | input | 1 | Clears the compare B flag |
| count_o | output | 8 | Current count |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| ovf_flag | output | 1 | Overflow flag |
| cmpa_flag | output | 1 | Compare A flag |
| cmpb_flag | output | 1 | Compare B flag |

## Verification
Two events can fall in the same cycle: a compare match that sets a flag and software acknowledging that flag. The bench provokes this in clear-on-compare mode by raising the acknowledge on exactly the tick on which the count leaves the compare A value. It then expects the flag to read set, and it expects a later acknowledge with no tick to clear it. A second overlap is a counter write followed by a tick that sits on the compare value. Here the bench expects the count to keep rising and no flag to be set.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_CTC    = 2'b01,
        MD_FAST   = 2'b10,
        MD_PHASE  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } omode_e;

    typedef struct packed {
        logic   run;
        omode_e om_b;
        omode_e om_a;
        tmode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_CMPA  = 2'd1;
    localparam logic [1:0] SEL_CMPB  = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    function automatic logic is_pwm(tmode_e m);
        return (m == MD_FAST) || (m == MD_PHASE);
    endfunction

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  tmode_e       mode,
    input  logic [W-1:0] top_a,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         hit_ok,
    output logic         upd,
    output logic         ovf_evt,
    output logic         blk
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic         blk;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        upd     = 1'b0;
        ovf_evt = 1'b0;
        hit_ok  = step && !st_q.blk && !load;
        if (mode != MD_PHASE) begin
            st_d.down = 1'b0;
        end
        if (load) begin
            st_d.cnt = load_val;
            st_d.blk = 1'b1;
        end else if (step) begin
            st_d.blk = 1'b0;
            case (mode)
                MD_PHASE: begin
                    if (!st_q.down) begin
                        if (st_q.cnt == MAXV) begin
                            st_d.down = 1'b1;
                            st_d.cnt  = st_q.cnt - ONE;
                            upd       = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.down = 1'b0;
                            st_d.cnt  = ONE;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                            ovf_evt  = (st_q.cnt == ONE);
                        end
                    end
                end
                MD_CTC: begin
                    if (hit_ok && st_q.cnt == top_a) begin
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                    ovf_evt = (st_q.cnt == MAXV);
                end
                default: begin
                    st_d.cnt = st_q.cnt + ONE;
                    ovf_evt  = (st_q.cnt == MAXV);
                    upd      = (mode == MD_FAST) && (st_q.cnt == MAXV);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;
    assign blk   = st_q.blk;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         hit_ok,
    input  logic         upd,
    input  tmode_e       mode,
    input  omode_e       om,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_d,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         force_s,
    input  logic         ack,
    output logic         wave,
    output logic         flag,
    output logic [W-1:0] act
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] act;
        logic         wave;
        logic         flag;
    } chstate_t;

    chstate_t st_d, st_q;
    logic     hit;
    logic     lvl;

    always_comb begin
        st_d = st_q;
        lvl  = 1'b0;
        hit  = hit_ok && (cnt_q == st_q.act);
        if (wr) begin
            st_d.shadow = wr_val;
        end
        if (!is_pwm(mode)) begin
            st_d.act = st_d.shadow;
        end else if (upd) begin
            st_d.act = st_q.shadow;
        end
        if (is_pwm(mode)) begin
            if (step) begin
                lvl = (mode == MD_FAST) ? (cnt_d <= st_d.act) : (cnt_d < st_d.act);
                case (om)
                    OM_CLEAR: st_d.wave = lvl;
                    OM_SET:   st_d.wave = !lvl;
                    default:  st_d.wave = st_q.wave;
                endcase
            end
        end else if (hit || force_s) begin
            case (om)
                OM_TOGGLE: st_d.wave = !st_q.wave;
                OM_CLEAR:  st_d.wave = 1'b0;
                OM_SET:    st_d.wave = 1'b1;
                default:   st_d.wave = st_q.wave;
            endcase
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (ack) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave = st_q.wave && (om != OM_OFF);
    assign flag = st_q.flag;
    assign act  = st_q.act;
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         force_a,
    input  logic         force_b,
    input  logic         ack_ovf,
    input  logic         ack_a,
    input  logic         ack_b,
    output logic [W-1:0] count_o,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovf_flag,
    output logic         cmpa_flag,
    output logic         cmpb_flag
);
    localparam int NCH = 2;

    typedef struct packed {
        ctrl_t ctrl;
        logic  ovf;
    } tstate_t;

    tstate_t      st_d, st_q;
    logic         step;
    logic         load;
    logic [W-1:0] cnt_d;
    logic         hit_ok, upd, ovf_evt, blk;
    logic [W-1:0] act_v [NCH];
    logic [NCH-1:0] wave_v, flag_v, force_v, ack_v, wr_v;
    omode_e       om_v [NCH];
    logic [W-1:0] act_a;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_sel == SEL_CTRL) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end
        if (ovf_evt) begin
            st_d.ovf = 1'b1;
        end else if (ack_ovf) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = tick_en && st_q.ctrl.run;
    assign load = wr_en && (wr_sel == SEL_COUNT);

    assign force_v = {force_b, force_a};
    assign ack_v   = {ack_b, ack_a};
    assign wr_v    = {wr_en && (wr_sel == SEL_CMPB), wr_en && (wr_sel == SEL_CMPA)};
    assign om_v[0] = st_q.ctrl.om_a;
    assign om_v[1] = st_q.ctrl.om_b;
    assign act_a   = act_v[0];

    tmr_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .mode     (st_q.ctrl.mode),
        .top_a    (act_a),
        .load     (load),
        .load_val (wr_data),
        .cnt_q    (count_o),
        .cnt_d    (cnt_d),
        .hit_ok   (hit_ok),
        .upd      (upd),
        .ovf_evt  (ovf_evt),
        .blk      (blk)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_cmp_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .hit_ok  (hit_ok),
            .upd     (upd),
            .mode    (st_q.ctrl.mode),
            .om      (om_v[i]),
            .cnt_q   (count_o),
            .cnt_d   (cnt_d),
            .wr      (wr_v[i]),
            .wr_val  (wr_data),
            .force_s (force_v[i]),
            .ack     (ack_v[i]),
            .wave    (wave_v[i]),
            .flag    (flag_v[i]),
            .act     (act_v[i])
        );
    end

    assign wave_a    = wave_v[0];
    assign wave_b    = wave_v[1];
    assign cmpa_flag = flag_v[0];
    assign cmpb_flag = flag_v[1];
    assign ovf_flag  = st_q.ovf;
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic [1:0]   mode,
    input logic         tick_en,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         force_a,
    input logic         ack_ovf,
    input logic         blk,
    input logic         hit_ok,
    input logic         ovf_evt,
    input logic [W-1:0] top_a,
    input logic [W-1:0] count_o,
    input logic         cmpa_flag,
    input logic         ovf_flag
);
    AST_STOPPED_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && wr_sel == 2'd0)) |=> $stable(count_o)); // R2

    AST_CTC_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && hit_ok && count_o == top_a) |=> (count_o == '0)); // R3

    AST_BLOCKED_TICK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && run && tick_en && !cmpa_flag) |=> !cmpa_flag); // R4

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a && !(run && tick_en) && !cmpa_flag) |=> !cmpa_flag); // R6

    AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf && !ovf_evt) |=> !ovf_flag); // R10
endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (st_q.ctrl.run),
    .mode      (st_q.ctrl.mode),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .force_a   (force_a),
    .ack_ovf   (ack_ovf),
    .blk       (blk),
    .hit_ok    (hit_ok),
    .ovf_evt   (ovf_evt),
    .top_a     (act_a),
    .count_o   (count_o),
    .cmpa_flag (cmpa_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       force_a = 1'b0, force_b = 1'b0;
    logic       ack_ovf = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
    logic [7:0] count_o;
    logic       wave_a, wave_b, ovf_flag, cmpa_flag, cmpb_flag;

    always #4 clk = ~clk;

    pwm_timer8 #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .force_a(force_a), .force_b(force_b),
        .ack_ovf(ack_ovf), .ack_a(ack_a), .ack_b(ack_b), .count_o(count_o),
        .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
        .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
    );

    localparam logic [12:0] M_ALL = 13'h1FFF;
    localparam logic [12:0] M_CNT = 13'h1FE0;
    localparam logic [12:0] M_WA  = 13'h0010;
    localparam logic [12:0] M_WB  = 13'h0008;
    localparam logic [12:0] M_OV  = 13'h0004;
    localparam logic [12:0] M_FA  = 13'h0002;
    localparam logic [12:0] M_FB  = 13'h0001;

    typedef struct {
        string       tag;
        logic [12:0] exp;
        logic [12:0] msk;
    } item_t;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    wire [12:0] obs = {count_o, wave_a, wave_b, ovf_flag, cmpa_flag, cmpb_flag};

    function automatic logic [12:0] mk(logic [7:0] c, logic wa, logic wb,
                                       logic ov, logic fa, logic fb);
        return {c, wa, wb, ov, fa, fb};
    endfunction

    // Monitor: compares the state after each edge against the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.msk != '0) begin
                    n_chk++;
                    if (((obs ^ it.exp) & it.msk) != '0) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h mask %h",
                                 it.tag, obs & it.msk, it.exp & it.msk, it.msk);
                    end
                end
            end
        end
    end

    // Driver: queue the expectation for the coming edge, then release strobes.
    task automatic go(string tag, logic [12:0] exp, logic [12:0] msk);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        it.msk = msk;
        sbq.push_back(it);
        @(negedge clk);
        wr_en   = 1'b0;
        force_a = 1'b0;
        force_b = 1'b0;
        ack_ovf = 1'b0;
        ack_a   = 1'b0;
        ack_b   = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) go("", '0, '0);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] val);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = val;
        go("", '0, '0);
    endtask

    task automatic ack_all(string tag);
        ack_ovf = 1'b1;
        ack_a = 1'b1;
        ack_b = 1'b1;
        go(tag, mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), M_OV | M_FA | M_FB);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        go("R1 reset", mk(8'h00, 0, 0, 0, 0, 0), M_ALL);

        // R2 count, hold on idle tick and on stopped run
        wr(2'd3, 8'h40);
        tick_en = 1'b1;
        go("R2 step1", mk(8'h01, 0, 0, 0, 0, 0), M_CNT);
        go("R2 step2", mk(8'h02, 0, 0, 0, 0, 0), M_CNT);
        tick_en = 1'b0;
        go("R2 no tick", mk(8'h02, 0, 0, 0, 0, 0), M_CNT);
        wr(2'd3, 8'h00);
        tick_en = 1'b1;
        go("R2 stopped", mk(8'h02, 0, 0, 0, 0, 0), M_CNT);
        tick_en = 1'b0;
        // R2 wrap and overflow flag
        wr(2'd0, 8'hFE);
        wr(2'd3, 8'h40);
        tick_en = 1'b1;
        go("R2 at FF", mk(8'hFF, 0, 0, 0, 0, 0), M_CNT | M_OV);
        go("R2 wrap", mk(8'h00, 0, 0, 1, 0, 0), M_CNT | M_OV);
        tick_en = 1'b0;
        ack_all("R10 ack");

        // R3 clear on compare A
        wr(2'd1, 8'h03);
        wr(2'd3, 8'h41);
        tick_en = 1'b1;
        idle(2);
        go("R3 reach A", mk(8'h03, 0, 0, 0, 0, 0), M_CNT | M_FA);
        go("R3 clear", mk(8'h00, 0, 0, 0, 1, 0), M_CNT | M_FA);
        tick_en = 1'b0;
        ack_a = 1'b1;
        go("R10 ack A", mk(8'h00, 0, 0, 0, 0, 0), M_FA);
        // R10 set and acknowledge in the same cycle
        tick_en = 1'b1;
        idle(3);
        ack_a = 1'b1;
        go("R10 set wins", mk(8'h00, 0, 0, 0, 1, 0), M_CNT | M_FA);
        tick_en = 1'b0;
        ack_a = 1'b1;
        go("R10 later ack", mk(8'h00, 0, 0, 0, 0, 0), M_FA);

        // R4 counter write masks the next tick's match
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h03;
        go("R4 load", mk(8'h03, 0, 0, 0, 0, 0), M_CNT);
        tick_en = 1'b1;
        go("R4 blocked", mk(8'h04, 0, 0, 0, 0, 0), M_CNT | M_FA);
        tick_en = 1'b0;

        // R5 toggle and set actions, normal mode
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h04);
        ack_all("R5 prep");
        tick_en = 1'b1;
        go("R5 pre", mk(8'h05, 0, 0, 0, 0, 0), M_CNT | M_WA | M_WB | M_FA);
        go("R5 match", mk(8'h06, 1, 1, 0, 1, 1), M_CNT | M_WA | M_WB | M_FA | M_FB);
        tick_en = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h40;
        go("R5 off low", mk(8'h06, 0, 0, 0, 0, 0), M_WA | M_WB);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h74;
        go("R5 state kept", mk(8'h06, 1, 1, 0, 0, 0), M_WA | M_WB);
        wr(2'd3, 8'h68);
        wr(2'd0, 8'h04);
        tick_en = 1'b1;
        idle(1);
        go("R5 clear", mk(8'h06, 0, 0, 0, 0, 0), M_CNT | M_WA | M_WB);
        tick_en = 1'b0;

        // R6 force strobes
        ack_all("R6 prep");
        wr(2'd3, 8'h74);
        force_a = 1'b1;
        force_b = 1'b1;
        go("R6 force", mk(8'h06, 1, 1, 0, 0, 0), M_ALL);
        force_a = 1'b1;
        go("R6 toggle", mk(8'h06, 0, 1, 0, 0, 0), M_ALL);

        // R7 fast PWM, R8 buffered compare
        wr(2'd3, 8'h7A);
        wr(2'd0, 8'h00);
        tick_en = 1'b1;
        go("R7 low count", mk(8'h01, 1, 0, 0, 0, 0), M_CNT | M_WA | M_WB);
        idle(4);
        go("R7 past cmp", mk(8'h06, 0, 1, 0, 0, 0), M_CNT | M_WA | M_WB);
        tick_en = 1'b0;
        ack_all("R7 prep");
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF;
        go("R8 write held", mk(8'h06, 0, 0, 0, 0, 0), M_WA);
        tick_en = 1'b1;
        go("R8 old active", mk(8'h07, 0, 0, 0, 0, 0), M_CNT | M_WA);
        idle(247);
        go("R8 before load", mk(8'hFF, 0, 0, 0, 0, 0), M_CNT | M_WA | M_OV);
        go("R7 wrap", mk(8'h00, 1, 0, 1, 0, 0), M_CNT | M_WA | M_OV);
        idle(127);
        go("R7 const mid", mk(8'h80, 1, 0, 0, 0, 0), M_CNT | M_WA);
        idle(126);
        go("R7 const top", mk(8'hFF, 1, 0, 0, 0, 0), M_CNT | M_WA);
        tick_en = 1'b0;

        // R9 phase-correct PWM, R8 load at TOP
        wr(2'd3, 8'h4B);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h10);
        ack_all("R9 prep");
        tick_en = 1'b1;
        idle(254);
        go("R9 top", mk(8'hFF, 0, 0, 0, 0, 0), M_CNT | M_WA | M_OV);
        go("R9 turn", mk(8'hFE, 0, 0, 0, 0, 0), M_CNT | M_WA);
        idle(237);
        go("R8 new active", mk(8'h10, 0, 0, 0, 0, 0), M_CNT | M_WA);
        go("R9 below cmp", mk(8'h0F, 1, 0, 0, 0, 0), M_CNT | M_WA | M_OV);
        idle(14);
        go("R9 bottom", mk(8'h00, 1, 0, 1, 0, 0), M_CNT | M_WA | M_OV);
        go("R9 up again", mk(8'h01, 1, 0, 1, 0, 0), M_CNT | M_WA | M_OV);
        tick_en = 1'b0;
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule